// File: doc/BRIEF.md
# Trigger Line Routing Matrix

This block steers trigger signals inside a chassis timing controller. It owns seventeen point-to-point star lines and eight shared bus trigger lines, twenty-five destinations in all. Every destination picks its own source from one flat code space: six front-panel inputs, the eight bus lines as they are read back, the star lines as they are read back, a one-cycle software trigger, a reference square wave taken from the shared timing clock, and an external clock input. Because the lines are bidirectional, a line that is switched off releases its pad so that the far module can drive it. Its read-back value can then feed any other route.

Each route runs in one of two modes. In pass-through mode the chosen source reaches the pad through a multiplexer with no register in the path. In resampled mode the source goes through a two-stage synchronizer. It then lands in an output register that loads only on the ticks of the route's rate: every cycle, or the tick of one of two programmable dividers. A flat register port holds one configuration word for each destination, the two divide values and the software trigger strobe. The block's clock is the shared timing clock.

Top module: `trig_route_matrix`

## Requirements
- R1: After reset every route word, both divide values and the software pulse are zero, all output enables are low and all line outputs are low.
- R2: Source codes are: front-panel input k is code k (0..5), bus line k is code 6+k, star line k is code 14+k, the software pulse is 31, the reference wave is 32, the external clock is 33; codes 34..63 select a constant low.
- R3: An enabled route in pass-through mode (mode bit 0) drives its line with the current value of the selected source, with no register between source and pad.
- R4: A write with cfg_we high takes effect at that clock edge. Addresses 0..16 hold the words for star lines 0..16, 17..24 hold those for bus lines 0..7, 25 holds divider one and 26 holds divider two (low 8 bits). A route word is laid out as source bits [5:0], enable bit 6, mode bit 7 and rate bits [9:8]. cfg_rdata returns the word at cfg_addr without delay, and address 27 reads as zero.
- R5: A route word whose source code equals the code of its own destination line is stored with the enable bit cleared, so that line stays released.
- R6: A disabled route holds its output enable low and its output low.
- R7: Writing 1 to bit 0 at address 27 raises the software pulse for exactly the one cycle after the write edge, and every route selecting code 31 sees it in that same cycle.
- R8: An enabled route in resampled mode (mode bit 1) at full rate (rate 0 or 3) shows a source change on its line after the third rising edge that follows the change.
- R9: Each divider restarts its count and emits a one-cycle tick when its count reaches or passes its divide value, so the tick period is value+1 cycles. A resampled route with rate 1 or 2 loads its output register only at edges where the tick of divider one or two is high.
- R10: The reference wave (code 32) is low in the first cycle after reset and inverts on every clock edge.
- R11: Star and bus lines used as sources are read from the line inputs, so a released line driven by a remote module can feed another route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared timing clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 10 | Register write data |
| cfg_rdata | output | 10 | Register read data at cfg_addr |
| fp_in | input | 6 | Front-panel trigger inputs |
| bus_in | input | 8 | Bus trigger line values read from the pads |
| star_in | input | 17 | Star line values read from the pads |
| clkin | input | 1 | External clock input |
| star_out | output | 17 | Star line drive values |
| star_oe | output | 17 | Star line output enables |
| bus_out | output | 8 | Bus line drive values |
| bus_oe | output | 8 | Bus line output enables |

## Verification
Pass-through routes and register reads answer within the same cycle as their inputs. Route and divider writes and the software pulse act after one edge, and a resampled route at full rate answers after three edges; divided routes answer at the first tick after their synchronizer holds the new value. Inputs change one nanosecond after a falling edge. All outputs are sampled on the falling edge, so every register result is read half a cycle after the edge that made it. A behavioural model advanced on the same rising edges predicts every line and enable on every cycle. Directed checks count the edges after a stimulus, one sample per edge, before reading.

// File: rtl/trm_pkg.sv
// Shared types for the trigger routing matrix.
// Assumes at most 64 source codes, so a six-bit selector is enough.
package trm_pkg;

    localparam int SRC_W = 6;

    // Rate selector of a resampled route; code 3 behaves like full rate.
    typedef enum logic [1:0] {
        RATE_FULL  = 2'd0,
        RATE_DIV1  = 2'd1,
        RATE_DIV2  = 2'd2,
        RATE_FULLB = 2'd3
    } rate_e;

    // One route word: rate, mode (1 = resampled), enable, source code.
    typedef struct packed {
        rate_e              rate;
        logic               sync;
        logic               en;
        logic [SRC_W-1:0]   src;
    } route_cfg_t;

    localparam int CFG_W = $bits(route_cfg_t);

    // Source code under which destination line 'line' is read back.
    function automatic int line_src_code(int line, int n_fp, int n_bus, int n_star);
        if (line < n_star) return n_fp + n_bus + line;
        return n_fp + (line - n_star);
    endfunction

endpackage

// File: rtl/trm_div.sv
// Rate divider: emits a registered one-cycle tick every div_val+1 cycles.
// Assumes div_val may change at any time; the count restarts once it
// reaches or passes the new value.
module trm_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count up, wrap at the divide value and flag the wrap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div_val) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/trm_cfg.sv
// Register file of the routing matrix: one route word per destination,
// two divide values and the software trigger strobe. Also makes the
// reference square wave. Assumes single-cycle writes and combinational reads.
module trm_cfg
    import trm_pkg::*;
#(
    parameter int N_STAR = 17,
    parameter int N_BUS  = 8,
    parameter int N_FP   = 6,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output route_cfg_t        cfg [N_STAR+N_BUS],
    output logic [DIV_W-1:0]  div1_val,
    output logic [DIV_W-1:0]  div2_val,
    output logic              sw_pulse,
    output logic              sync_ref
);

    localparam int N_LINE    = N_STAR + N_BUS;
    localparam int DIV1_ADDR = N_LINE;
    localparam int DIV2_ADDR = N_LINE + 1;
    localparam int SW_ADDR   = N_LINE + 2;

    route_cfg_t wcfg;
    assign wcfg = route_cfg_t'(wdata);

    // Store route words, clearing enable when a route names its own line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LINE; i++) cfg[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < N_LINE; i++) begin
                if (addr == ADDR_W'(i)) begin
                    cfg[i] <= wcfg;
                    if (wcfg.src == SRC_W'(line_src_code(i, N_FP, N_BUS, N_STAR)))
                        cfg[i].en <= 1'b0;
                end
            end
        end
    end

    // Store the two divide values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div1_val <= '0;
            div2_val <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(DIV1_ADDR)) div1_val <= wdata[DIV_W-1:0];
            if (addr == ADDR_W'(DIV2_ADDR)) div2_val <= wdata[DIV_W-1:0];
        end
    end

    // One-cycle software trigger raised by a write of 1 to the strobe address.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_pulse <= 1'b0;
        else        sw_pulse <= we && (addr == ADDR_W'(SW_ADDR)) && wdata[0];
    end

    // Reference square wave at half the timing clock rate.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_ref <= 1'b0;
        else        sync_ref <= ~sync_ref;
    end

    // Read multiplexer over route words and divide values.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_LINE; i++)
            if (addr == ADDR_W'(i)) rdata = cfg[i];
        if (addr == ADDR_W'(DIV1_ADDR)) rdata = CFG_W'(div1_val);
        if (addr == ADDR_W'(DIV2_ADDR)) rdata = CFG_W'(div2_val);
    end

endmodule

// File: rtl/trm_route.sv
// One destination route: source select, optional resampling, pad drive.
// Assumes the source vector is ordered by source code and that codes at
// or above N_SRC select a constant low.
module trm_route
    import trm_pkg::*;
#(
    parameter int N_SRC = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  route_cfg_t       cfg,
    input  logic [N_SRC-1:0] src_vec,
    input  logic             tick_div1,
    input  logic             tick_div2,
    output logic             line_out,
    output logic             line_oe,
    output logic             rate_tick
);

    logic sel;
    logic meta_q;
    logic sync_q;
    logic hold_q;

    // Pick the source bit named by the route word.
    always_comb begin
        if (int'(cfg.src) < N_SRC) sel = src_vec[cfg.src];
        else                       sel = 1'b0;
    end

    // Choose the load strobe for the resampled output register.
    always_comb begin
        unique case (cfg.rate)
            RATE_DIV1: rate_tick = tick_div1;
            RATE_DIV2: rate_tick = tick_div2;
            default:   rate_tick = 1'b1;
        endcase
    end

    // Two-stage synchronizer followed by a rate-gated output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            meta_q <= sel;
            sync_q <= meta_q;
            if (rate_tick) hold_q <= sync_q;
        end
    end

    // Drive the pad only while enabled, from the path the mode selects.
    always_comb begin
        line_oe  = cfg.en;
        line_out = cfg.en & (cfg.sync ? hold_q : sel);
    end

endmodule

// File: rtl/trig_route_matrix.sv
// Top of the trigger routing matrix: register file, two rate dividers and
// one route per star and bus line. Assumes clk is the shared timing clock
// and that pad tri-state buffers sit outside, driven by *_out and *_oe.
module trig_route_matrix
    import trm_pkg::*;
#(
    parameter int N_STAR = 17,
    parameter int N_BUS  = 8,
    parameter int N_FP   = 6,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [trm_pkg::CFG_W-1:0] cfg_wdata,
    output logic [trm_pkg::CFG_W-1:0] cfg_rdata,
    input  logic [N_FP-1:0]        fp_in,
    input  logic [N_BUS-1:0]       bus_in,
    input  logic [N_STAR-1:0]      star_in,
    input  logic                   clkin,
    output logic [N_STAR-1:0]      star_out,
    output logic [N_STAR-1:0]      star_oe,
    output logic [N_BUS-1:0]       bus_out,
    output logic [N_BUS-1:0]       bus_oe
);

    localparam int N_LINE = N_STAR + N_BUS;
    localparam int N_SRC  = N_FP + N_BUS + N_STAR + 3;

    route_cfg_t        route_cfg [N_LINE];
    logic [DIV_W-1:0]  div_val   [2];
    logic [1:0]        div_tick;
    logic              sw_pulse;
    logic              sync_ref;
    logic [N_SRC-1:0]  src_vec;
    logic [N_LINE-1:0] line_out;
    logic [N_LINE-1:0] line_oe;
    logic [N_LINE-1:0] rate_tick;

    trm_cfg #(
        .N_STAR (N_STAR),
        .N_BUS  (N_BUS),
        .N_FP   (N_FP),
        .DIV_W  (DIV_W),
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .cfg      (route_cfg),
        .div1_val (div_val[0]),
        .div2_val (div_val[1]),
        .sw_pulse (sw_pulse),
        .sync_ref (sync_ref)
    );

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_div
            trm_div #(.DIV_W(DIV_W)) u_div (
                .clk     (clk),
                .rst_n   (rst_n),
                .div_val (div_val[k]),
                .tick    (div_tick[k])
            );
        end
    endgenerate

    // Source vector in code order: panel, bus, star, software, reference, external.
    assign src_vec = {clkin, sync_ref, sw_pulse, star_in, bus_in, fp_in};

    genvar l;
    generate
        for (l = 0; l < N_LINE; l++) begin : g_route
            trm_route #(.N_SRC(N_SRC)) u_route (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg       (route_cfg[l]),
                .src_vec   (src_vec),
                .tick_div1 (div_tick[0]),
                .tick_div2 (div_tick[1]),
                .line_out  (line_out[l]),
                .line_oe   (line_oe[l]),
                .rate_tick (rate_tick[l])
            );
        end
    endgenerate

    assign star_out = line_out[N_STAR-1:0];
    assign star_oe  = line_oe[N_STAR-1:0];
    assign bus_out  = line_out[N_LINE-1:N_STAR];
    assign bus_oe   = line_oe[N_LINE-1:N_STAR];

endmodule

// File: rtl/trm_checker.sv
// Temporal checks on the routing matrix, attached to the top by bind.
// Assumes the top's internal names route_cfg, rate_tick, div_tick, div_val,
// sw_pulse and sync_ref.
module trm_checker
    import trm_pkg::*;
#(
    parameter int N_STAR = 17,
    parameter int N_BUS  = 8,
    parameter int N_FP   = 6,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [ADDR_W-1:0]        cfg_addr,
    input logic [SRC_W-1:0]         wr_src,
    input logic [N_STAR+N_BUS-1:0]  line_out,
    input logic [N_STAR+N_BUS-1:0]  line_oe,
    input logic [N_STAR+N_BUS-1:0]  rate_tick,
    input route_cfg_t               cfg [N_STAR+N_BUS],
    input logic [1:0]               div_tick,
    input logic [DIV_W-1:0]         div_val [2],
    input logic                     sw_pulse,
    input logic                     sync_ref
);

    localparam int N_LINE = N_STAR + N_BUS;

    genvar i;
    generate
        for (i = 0; i < N_LINE; i++) begin : g_line
            localparam int SELF = line_src_code(i, N_FP, N_BUS, N_STAR);

            AST_SELF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_we && cfg_addr == ADDR_W'(i) && wr_src == SRC_W'(SELF) |=> !line_oe[i]); // R5

            AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                !line_oe[i] |-> !line_out[i]); // R6

            AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                cfg[i].en && cfg[i].sync && $stable(cfg[i]) && !$past(rate_tick[i])
                |-> $stable(line_out[i])); // R9
        end
        for (i = 0; i < 2; i++) begin : g_div
            AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                div_tick[i] && div_val[i] != '0 |=> !div_tick[i]); // R9
        end
    endgenerate

    AST_SW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pulse |=> !sw_pulse); // R7

    AST_REF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sync_ref != $past(sync_ref)); // R10

endmodule

bind trig_route_matrix trm_checker #(
    .N_STAR (N_STAR),
    .N_BUS  (N_BUS),
    .N_FP   (N_FP),
    .DIV_W  (DIV_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .wr_src    (cfg_wdata[trm_pkg::SRC_W-1:0]),
    .line_out  (line_out),
    .line_oe   (line_oe),
    .rate_tick (rate_tick),
    .cfg       (route_cfg),
    .div_tick  (div_tick),
    .div_val   (div_val),
    .sw_pulse  (sw_pulse),
    .sync_ref  (sync_ref)
);

// File: tb/tb_trig_route_matrix.sv
`timescale 1ns/1ps
module tb_trig_route_matrix;

    localparam int NS = 17, NB = 8, NF = 6, NL = 25;

    logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [9:0]  cfg_wdata = '0;
    logic [9:0]  cfg_rdata;
    logic [5:0]  fp_in = '0;
    logic [7:0]  bus_in = '0;
    logic [16:0] star_in = '0;
    logic        clkin = 1'b0;
    logic [16:0] star_out, star_oe;
    logic [7:0]  bus_out, bus_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    trig_route_matrix dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fp_in(fp_in),
        .bus_in(bus_in), .star_in(star_in), .clkin(clkin),
        .star_out(star_out), .star_oe(star_oe), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    logic [9:0] m_cfg [NL];
    int         m_dv [2];
    int         m_cnt [2];
    bit         m_tk [2];
    bit         m_sw, m_ref;
    bit         m_hist [NL][3];   // [0] newest sample ... [2] loaded value
    logic [9:0] m_w;

    function automatic int self_code(int l);
        return (l < NS) ? 14 + l : l - 11;
    endfunction

    function automatic bit srcv(int c);
        if (c < 6)  return fp_in[c];
        if (c < 14) return bus_in[c-6];
        if (c < 31) return star_in[c-14];
        if (c == 31) return m_sw;
        if (c == 32) return m_ref;
        if (c == 33) return clkin;
        return 1'b0;
    endfunction

    function automatic bit tick_of(int l);
        case (m_cfg[l][9:8])
            2'd1: return m_tk[0];
            2'd2: return m_tk[1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit exp_out(int l);
        if (!m_cfg[l][6]) return 1'b0;
        if (m_cfg[l][7])  return m_hist[l][2];
        return srcv(int'(m_cfg[l][5:0]));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NL; l++) begin
                m_cfg[l] <= '0;
                for (int s = 0; s < 3; s++) m_hist[l][s] <= 1'b0;
            end
            for (int k = 0; k < 2; k++) begin
                m_dv[k] <= 0; m_cnt[k] <= 0; m_tk[k] <= 1'b0;
            end
            m_sw <= 1'b0; m_ref <= 1'b0;
        end else begin
            for (int l = 0; l < NL; l++) begin
                m_hist[l][0] <= srcv(int'(m_cfg[l][5:0]));
                m_hist[l][1] <= m_hist[l][0];
                if (tick_of(l)) m_hist[l][2] <= m_hist[l][1];
            end
            for (int k = 0; k < 2; k++) begin
                if (m_cnt[k] >= m_dv[k]) begin m_cnt[k] <= 0; m_tk[k] <= 1'b1; end
                else begin m_cnt[k] <= m_cnt[k] + 1; m_tk[k] <= 1'b0; end
            end
            m_ref <= !m_ref;
            m_sw  <= cfg_we && cfg_addr == 5'd27 && cfg_wdata[0];
            if (cfg_we) begin
                if (cfg_addr < NL) begin
                    m_w = cfg_wdata;
                    if (int'(m_w[5:0]) == self_code(int'(cfg_addr))) m_w[6] = 1'b0;
                    m_cfg[cfg_addr] <= m_w;
                end else if (cfg_addr == 5'd25) m_dv[0] <= int'(cfg_wdata[7:0]);
                else if (cfg_addr == 5'd26) m_dv[1] <= int'(cfg_wdata[7:0]);
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Every line and enable compared with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int l = 0; l < NL; l++) begin
                logic o, e;
                string tag;
                o = (l < NS) ? star_out[l] : bus_out[l-NS];
                e = (l < NS) ? star_oe[l]  : bus_oe[l-NS];
                chk($sformatf("R6 enable of line %0d", l), 32'(e), 32'(m_cfg[l][6]));
                if (!m_cfg[l][6])                 tag = "R6 released";
                else if (!m_cfg[l][7])            tag = "R3 pass-through";
                else if (m_cfg[l][9:8] inside {2'd1, 2'd2}) tag = "R9 divided";
                else                              tag = "R8 full-rate";
                chk($sformatf("%s line %0d", tag, l), 32'(o), 32'(exp_out(l)));
            end
        end
    end

    task automatic wr(int a, logic [9:0] d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rdchk(string tag, int a, logic [9:0] exp);
        @(negedge clk); #1;
        cfg_addr = 5'(a);
        #0.5;
        chk(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    function automatic logic [9:0] mk(int src, bit en, bit sy, int rate);
        return {2'(rate), sy, en, 6'(src)};
    endfunction

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        bit v;
        repeat (4) @(negedge clk);
        // R1: state while still held in reset after several edges
        chk("R1 star enables", 32'(star_oe), 0);
        chk("R1 bus enables", 32'(bus_oe), 0);
        chk("R1 star outputs", 32'(star_out), 0);
        #1 rst_n = 1'b1;
        rdchk("R1 route word 0", 0, 10'h0);
        rdchk("R1 divider one", 25, 10'h0);

        // R2 / R3: star 0 passes front-panel input 2
        wr(0, mk(2, 1, 0, 0));
        rdchk("R4 readback route word", 0, mk(2, 1, 0, 0));
        @(negedge clk); #1 fp_in[2] = 1'b1;
        @(negedge clk); chk("R2 R3 panel input 2 on star 0", 32'(star_out[0]), 1);
        #1 fp_in[2] = 1'b0;
        @(negedge clk); chk("R3 star 0 follows low", 32'(star_out[0]), 0);

        // R11: bus 3 (address 20) takes star line 5 read back (code 19)
        wr(20, mk(19, 1, 0, 0));
        @(negedge clk); #1 star_in[5] = 1'b1;
        @(negedge clk); chk("R11 star 5 input to bus 3", 32'(bus_out[3]), 1);
        #1 star_in[5] = 1'b0;

        // R2: bus 7 (address 24) takes the external clock input (code 33)
        wr(24, mk(33, 1, 0, 0));
        @(negedge clk); #1 clkin = 1'b1;
        @(negedge clk); chk("R2 external clock on bus 7", 32'(bus_out[7]), 1);
        #1 clkin = 1'b0;

        // R5: star 4 names itself (code 18)
        wr(4, mk(18, 1, 0, 0));
        rdchk("R5 self route stored disabled", 4, mk(18, 0, 0, 0));
        @(negedge clk); chk("R5 star 4 released", 32'(star_oe[4]), 0);

        // R7: software pulse on star 1 and bus 0 in the same cycle
        wr(1, mk(31, 1, 0, 0));
        wr(17, mk(31, 1, 0, 0));
        wr(27, 10'h1);
        chk("R7 pulse on star 1", 32'(star_out[1]), 1);
        chk("R7 pulse on bus 0", 32'(bus_out[0]), 1);
        @(negedge clk);
        chk("R7 pulse over on star 1", 32'(star_out[1]), 0);
        rdchk("R4 strobe address reads zero", 27, 10'h0);

        // R8: star 2 resampled at full rate from panel input 0
        wr(2, mk(0, 1, 1, 0));
        repeat (4) @(negedge clk);
        #1 fp_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R8 not yet after two edges", 32'(star_out[2]), 0);
        @(negedge clk); chk("R8 visible after three edges", 32'(star_out[2]), 1);

        // R10: star 6 carries the reference wave
        wr(6, mk(32, 1, 0, 0));
        @(negedge clk); v = star_out[6];
        @(negedge clk); chk("R10 reference inverts", 32'(star_out[6]), 32'(!v));

        // R9: divided routes checked cycle by cycle against the model
        wr(25, 10'd3);
        rdchk("R4 divider one readback", 25, 10'd3);
        wr(26, 10'd1);
        wr(3, mk(1, 1, 1, 1));
        wr(18, mk(1, 1, 1, 2));

        // R6: disabling a route releases it
        wr(0, mk(2, 0, 0, 0));
        @(negedge clk); chk("R6 star 0 released", 32'(star_oe[0]), 0);

        // Mixed traffic with random writes; the model checks every line
        for (int it = 0; it < 3000; it++) begin
            @(negedge clk); #1;
            fp_in   = 6'($urandom);
            bus_in  = 8'($urandom);
            star_in = 17'($urandom);
            clkin   = 1'($urandom);
            cfg_we  = ($urandom % 6 == 0);
            cfg_addr = 5'($urandom % 28);
            if (cfg_addr == 5'd25 || cfg_addr == 5'd26) cfg_wdata = 10'($urandom % 6);
            else cfg_wdata = {2'($urandom), 1'($urandom), 1'($urandom), 6'($urandom % 36)};
        end
        @(negedge clk); #1 cfg_we = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule